// File: doc/BRIEF.md
# Far Call Target Privilege Checker

This block decides whether a far transfer of control may proceed. It takes the target selector, the current privilege level, the long-mode flag and the fields of the descriptor that the selector names, already fetched by the surrounding pipeline. It classifies the target as a conforming code segment, a nonconforming code segment, a call gate, a task gate or a task state segment. It then runs the privilege and presence rules for that class and reports either success or the first fault found.

For a call gate the block also takes the fields of the code descriptor that the gate points to. It checks that descriptor as well and reports whether the call enters a more privileged level, so that the caller can choose the path that switches stacks. A request is presented for one cycle on `req_valid`. The verdict appears on the registered outputs in the next cycle, qualified by `res_valid`.

Selectors are `{index, table, rpl}`: the lowest two bits are the requested privilege, the next bit selects the local table (1) or the global table (0), and the index sits above them. Descriptor kinds arrive on `dsc_kind` as 0 = data or other, 1 = conforming code, 2 = nonconforming code, 3 = legacy call gate, 4 = 64-bit call gate, 5 = task gate, 6 = idle TSS, 7 = busy TSS. The result class codes are 0 = none, 1 = conforming, 2 = nonconforming, 3 = call gate, 4 = task gate, 5 = TSS. The fault codes are 0 = none, 1 = general protection (GP), 2 = not present (NP).

Top module: `fcall_priv_check`

## Requirements
- R1: A selector with index 0 in the global table yields fault GP, error selector 0 and class 0.
- R2: A selector whose index is greater than `tbl_limit` yields fault GP with the target selector as the error selector, and class 0.
- R3: Outside long mode, kinds 1, 2, 3, 5, 6 and 7 are accepted. Kinds 0 and 4 yield GP with the target selector and class 0.
- R4: In long mode, only kinds 1, 2 and 4 are accepted. Any other kind yields GP with the target selector and class 0.
- R5: In long mode, a code segment (kind 1 or 2) that has both `dsc_l` and `dsc_d` set yields GP with the target selector.
- R6: For conforming code, DPL greater than CPL yields GP with the target selector.
- R7: For nonconforming code, RPL greater than CPL, or DPL not equal to CPL, yields GP with the target selector.
- R8: For a call gate, gate DPL below CPL, or RPL above gate DPL, yields GP with the target selector. A gate that passes these checks but is not present yields NP with the target selector.
- R9: For a present call gate, the gate's code descriptor is checked next. It yields GP with `tgt_sel` if that descriptor is not code or its DPL exceeds CPL. In long mode it also yields GP with `tgt_sel` unless L is 1 and D is 0. If all of these pass but the descriptor is not present, the result is NP with `tgt_sel`.
- R10: A call gate that raises no fault sets `res_more_priv` when its target is nonconforming with DPL below CPL. `res_more_priv` is 0 in every other case.
- R11: For a task gate or TSS, DPL below CPL or below RPL yields GP with the target selector. A TSS of kind 7, or a TSS selected from the local table, also yields GP with the target selector.
- R12: The present bit of the selected descriptor is tested only after its type and privilege checks. When it is clear, the result is NP with the target selector, and the class stays reported.
- R13: Only the first failing check in the order R1, R2, R3/R4, then the class rules, is reported. The result appears with `res_valid` high exactly one cycle after `req_valid`, and `res_valid` is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per check |
| sel_index | input | IDX_W | Target selector index |
| sel_table | input | 1 | Target selector table bit (1 = local) |
| sel_rpl | input | 2 | Target selector requested privilege |
| cur_cpl | input | 2 | Current privilege level |
| long_mode | input | 1 | Long mode active |
| tbl_limit | input | IDX_W | Highest valid index in the selected table |
| dsc_kind | input | 3 | Kind code of the selected descriptor |
| dsc_dpl | input | 2 | Descriptor privilege level |
| dsc_present | input | 1 | Descriptor present bit |
| dsc_l | input | 1 | Descriptor 64-bit code bit |
| dsc_d | input | 1 | Descriptor default-size bit |
| tgt_sel | input | IDX_W+3 | Code selector held in a call gate |
| tgt_is_code | input | 1 | Gate target descriptor is a code segment |
| tgt_conforming | input | 1 | Gate target code segment is conforming |
| tgt_dpl | input | 2 | Gate target DPL |
| tgt_present | input | 1 | Gate target present bit |
| tgt_l | input | 1 | Gate target 64-bit code bit |
| tgt_d | input | 1 | Gate target default-size bit |
| res_valid | output | 1 | Verdict valid |
| res_class | output | 3 | Class code |
| res_fault | output | 2 | Fault code |
| res_err_sel | output | IDX_W+3 | Selector reported with the fault |
| res_more_priv | output | 1 | Gate call enters a more privileged level |

## Verification
On every cycle, the assertions check the timing of the verdict and the null-selector outcome. They also check that the long-mode type screen and the L/D rule for code segments give GP, that a not-present result always carries a class, and that the more-privilege flag appears only with a clean call-gate verdict. The privilege comparisons for each class, the gate-target checks and the order in which competing faults are reported can only be shown by the bench. It does this with directed cases aimed at each rule and with a broad sweep of mixed descriptors, compared against an independent model.

// File: rtl/fcall_pkg.sv
// Shared encodings for the far call checker.
// Assumes: kind, class and fault codes fixed as listed in the brief.
package fcall_pkg;
    typedef enum logic [2:0] {
        K_DATA     = 3'd0,
        K_CONF     = 3'd1,
        K_NCONF    = 3'd2,
        K_GATE_LEG = 3'd3,
        K_GATE_64  = 3'd4,
        K_TGATE    = 3'd5,
        K_TSS_FREE = 3'd6,
        K_TSS_BUSY = 3'd7
    } kind_e;

    typedef enum logic [2:0] {
        C_NONE  = 3'd0,
        C_CONF  = 3'd1,
        C_NCONF = 3'd2,
        C_GATE  = 3'd3,
        C_TGATE = 3'd4,
        C_TSS   = 3'd5
    } class_e;

    typedef enum logic [1:0] {
        F_NONE = 2'd0,
        F_GP   = 2'd1,
        F_NP   = 2'd2
    } fault_e;

    // Which selector accompanies a fault.
    typedef enum logic [1:0] {
        E_ZERO = 2'd0,
        E_SEL  = 2'd1,
        E_TGT  = 2'd2
    } errsrc_e;

    typedef struct packed {
        fault_e  fault;
        errsrc_e src;
    } verdict_t;
endpackage

// File: rtl/fcall_sel_screen.sv
// Screens the target selector: null test, table limit, and the set of
// descriptor kinds allowed in the current mode. Produces the class.
// Assumes: tbl_limit is the highest usable index of the chosen table.
module fcall_sel_screen
    import fcall_pkg::*;
#(
    parameter int IDX_W = 13
) (
    input  logic [IDX_W-1:0] sel_index,
    input  logic             sel_table,
    input  logic [IDX_W-1:0] tbl_limit,
    input  logic             long_mode,
    input  logic [2:0]       dsc_kind,
    output verdict_t         scr_verdict,
    output class_e           scr_class
);
    logic is_null;
    logic over_limit;
    logic kind_ok;
    class_e kind_class;

    // Decide whether the kind is legal in the current mode and map it to a class.
    always_comb begin
        kind_ok    = 1'b0;
        kind_class = C_NONE;
        case (kind_e'(dsc_kind))
            K_CONF:     begin kind_ok = 1'b1;       kind_class = C_CONF;  end
            K_NCONF:    begin kind_ok = 1'b1;       kind_class = C_NCONF; end
            K_GATE_LEG: begin kind_ok = !long_mode; kind_class = C_GATE;  end
            K_GATE_64:  begin kind_ok = long_mode;  kind_class = C_GATE;  end
            K_TGATE:    begin kind_ok = !long_mode; kind_class = C_TGATE; end
            K_TSS_FREE,
            K_TSS_BUSY: begin kind_ok = !long_mode; kind_class = C_TSS;   end
            default:    begin kind_ok = 1'b0;       kind_class = C_NONE;  end
        endcase
    end

    assign is_null    = (sel_index == '0) && !sel_table;
    assign over_limit = sel_index > tbl_limit;

    // Report the first screen failure; a passing screen yields the class.
    always_comb begin
        scr_verdict = '{fault: F_NONE, src: E_ZERO};
        scr_class   = C_NONE;
        if (is_null)
            scr_verdict = '{fault: F_GP, src: E_ZERO};
        else if (over_limit || !kind_ok)
            scr_verdict = '{fault: F_GP, src: E_SEL};
        else
            scr_class = kind_class;
    end
endmodule

// File: rtl/fcall_seg_rules.sv
// Privilege and presence rules for direct code targets and for task targets
// (task gate or TSS).
// Assumes: the class already passed the selector screen.
module fcall_seg_rules
    import fcall_pkg::*;
(
    input  class_e     cls,
    input  logic       long_mode,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    input  logic       sel_table,
    input  logic [2:0] dsc_kind,
    input  logic [1:0] dsc_dpl,
    input  logic       dsc_present,
    input  logic       dsc_l,
    input  logic       dsc_d,
    output verdict_t   seg_verdict
);
    logic bad_ld;
    logic priv_fail;

    assign bad_ld = long_mode && dsc_l && dsc_d;

    // Pick the privilege test belonging to the class.
    always_comb begin
        case (cls)
            C_CONF:  priv_fail = bad_ld || (dsc_dpl > cpl);
            C_NCONF: priv_fail = bad_ld || (rpl > cpl) || (dsc_dpl != cpl);
            C_TGATE: priv_fail = (dsc_dpl < cpl) || (dsc_dpl < rpl);
            C_TSS:   priv_fail = (dsc_dpl < cpl) || (dsc_dpl < rpl) ||
                                 (dsc_kind == K_TSS_BUSY) || sel_table;
            default: priv_fail = 1'b0;
        endcase
    end

    // Privilege faults first, then the present bit.
    always_comb begin
        if (priv_fail)
            seg_verdict = '{fault: F_GP, src: E_SEL};
        else if (!dsc_present)
            seg_verdict = '{fault: F_NP, src: E_SEL};
        else
            seg_verdict = '{fault: F_NONE, src: E_ZERO};
    end
endmodule

// File: rtl/fcall_gate_rules.sv
// Call-gate rules: checks the gate itself, then the code descriptor it names,
// and chooses between the same-privilege and more-privilege paths.
// Assumes: the gate kind already matched the current mode.
module fcall_gate_rules
    import fcall_pkg::*;
(
    input  logic       long_mode,
    input  logic [1:0] cpl,
    input  logic [1:0] rpl,
    input  logic [1:0] gate_dpl,
    input  logic       gate_present,
    input  logic       tgt_is_code,
    input  logic       tgt_conforming,
    input  logic [1:0] tgt_dpl,
    input  logic       tgt_present,
    input  logic       tgt_l,
    input  logic       tgt_d,
    output verdict_t   gate_verdict,
    output logic       gate_more_priv
);
    logic gate_priv_fail;
    logic tgt_fail;

    assign gate_priv_fail = (gate_dpl < cpl) || (rpl > gate_dpl);
    assign tgt_fail = !tgt_is_code || (tgt_dpl > cpl) ||
                      (long_mode && (!tgt_l || tgt_d));

    // Walk the gate checks in order; the first failure wins.
    always_comb begin
        gate_more_priv = 1'b0;
        if (gate_priv_fail)
            gate_verdict = '{fault: F_GP, src: E_SEL};
        else if (!gate_present)
            gate_verdict = '{fault: F_NP, src: E_SEL};
        else if (tgt_fail)
            gate_verdict = '{fault: F_GP, src: E_TGT};
        else if (!tgt_present)
            gate_verdict = '{fault: F_NP, src: E_TGT};
        else begin
            gate_verdict   = '{fault: F_NONE, src: E_ZERO};
            gate_more_priv = !tgt_conforming && (tgt_dpl < cpl);
        end
    end
endmodule

// File: rtl/fcall_priv_check.sv
// Far call target checker top: screens the selector, applies the rules of
// the selected class, and registers the verdict one cycle after the request.
// Assumes: all descriptor fields are stable while req_valid is high.
module fcall_priv_check
    import fcall_pkg::*;
#(
    parameter int IDX_W = 13,
    localparam int SEL_W = IDX_W + 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] sel_index,
    input  logic             sel_table,
    input  logic [1:0]       sel_rpl,
    input  logic [1:0]       cur_cpl,
    input  logic             long_mode,
    input  logic [IDX_W-1:0] tbl_limit,
    input  logic [2:0]       dsc_kind,
    input  logic [1:0]       dsc_dpl,
    input  logic             dsc_present,
    input  logic             dsc_l,
    input  logic             dsc_d,
    input  logic [SEL_W-1:0] tgt_sel,
    input  logic             tgt_is_code,
    input  logic             tgt_conforming,
    input  logic [1:0]       tgt_dpl,
    input  logic             tgt_present,
    input  logic             tgt_l,
    input  logic             tgt_d,
    output logic             res_valid,
    output logic [2:0]       res_class,
    output logic [1:0]       res_fault,
    output logic [SEL_W-1:0] res_err_sel,
    output logic             res_more_priv
);
    verdict_t   scr_v, seg_v, gate_v, final_v;
    class_e     cls;
    logic       gate_mp;
    logic       nxt_mp;
    logic [SEL_W-1:0] full_sel;
    logic [SEL_W-1:0] nxt_err;

    assign full_sel = {sel_index, sel_table, sel_rpl};

    fcall_sel_screen #(.IDX_W(IDX_W)) screen_i (
        .sel_index   (sel_index),
        .sel_table   (sel_table),
        .tbl_limit   (tbl_limit),
        .long_mode   (long_mode),
        .dsc_kind    (dsc_kind),
        .scr_verdict (scr_v),
        .scr_class   (cls)
    );

    fcall_seg_rules seg_i (
        .cls         (cls),
        .long_mode   (long_mode),
        .cpl         (cur_cpl),
        .rpl         (sel_rpl),
        .sel_table   (sel_table),
        .dsc_kind    (dsc_kind),
        .dsc_dpl     (dsc_dpl),
        .dsc_present (dsc_present),
        .dsc_l       (dsc_l),
        .dsc_d       (dsc_d),
        .seg_verdict (seg_v)
    );

    fcall_gate_rules gate_i (
        .long_mode      (long_mode),
        .cpl            (cur_cpl),
        .rpl            (sel_rpl),
        .gate_dpl       (dsc_dpl),
        .gate_present   (dsc_present),
        .tgt_is_code    (tgt_is_code),
        .tgt_conforming (tgt_conforming),
        .tgt_dpl        (tgt_dpl),
        .tgt_present    (tgt_present),
        .tgt_l          (tgt_l),
        .tgt_d          (tgt_d),
        .gate_verdict   (gate_v),
        .gate_more_priv (gate_mp)
    );

    // Merge: screen faults first, then the rules of the chosen class.
    always_comb begin
        nxt_mp = 1'b0;
        if (scr_v.fault != F_NONE)
            final_v = scr_v;
        else if (cls == C_GATE) begin
            final_v = gate_v;
            nxt_mp  = gate_mp;
        end else
            final_v = seg_v;
    end

    // Resolve the selector that accompanies the verdict.
    always_comb begin
        case (final_v.src)
            E_SEL:   nxt_err = full_sel;
            E_TGT:   nxt_err = tgt_sel;
            default: nxt_err = '0;
        endcase
    end

    // Register the verdict one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid     <= 1'b0;
            res_class     <= '0;
            res_fault     <= '0;
            res_err_sel   <= '0;
            res_more_priv <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_class     <= cls;
                res_fault     <= final_v.fault;
                res_err_sel   <= nxt_err;
                res_more_priv <= nxt_mp;
            end
        end
    end

    // Verdict timing follows the request strobe.
    assert_valid_timing_R13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    assert_valid_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);

    // A null global selector always faults with a zero error selector.
    assert_null_gp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && sel_index == '0 && !sel_table) |=>
        (res_fault == F_GP && res_err_sel == '0 && res_class == C_NONE));

    // Long mode rejects task gates, TSS kinds, data and legacy gates.
    assert_lm_types_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && long_mode && sel_index != '0 && sel_index <= tbl_limit &&
         !(dsc_kind inside {3'd1, 3'd2, 3'd4})) |=>
        (res_fault == F_GP && res_class == C_NONE && res_err_sel == $past(full_sel)));

    // Long-mode code with both L and D set is rejected.
    assert_lm_ld_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && long_mode && (sel_index != '0 || sel_table) &&
         sel_index <= tbl_limit && dsc_kind inside {3'd1, 3'd2} && dsc_l && dsc_d) |=>
        (res_fault == F_GP && res_err_sel == $past(full_sel)));

    // A not-present verdict is only reached once a class was established.
    assert_np_has_class_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault == F_NP) |-> (res_class != C_NONE));

    // The raised-privilege flag only accompanies a clean gate verdict.
    assert_more_priv_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_more_priv) |-> (res_class == C_GATE && res_fault == F_NONE));
endmodule

// File: tb/fcall_priv_check_tb_top.sv
// Scoreboard bench: the driver pushes modelled verdicts, the monitor pops and compares.
module fcall_priv_check_tb_top;
    localparam int IDX_W = 13;
    localparam int SEL_W = IDX_W + 3;
    localparam time CLK_PERIOD = 10ns;

    typedef struct {
        logic [2:0]       cls;
        logic [1:0]       fault;
        logic [SEL_W-1:0] err;
        logic             mp;
        string            tag;
    } exp_t;

    typedef struct {
        logic [IDX_W-1:0] idx;
        logic             tbl;
        logic [1:0]       rpl;
        logic [1:0]       cpl;
        logic             lm;
        logic [IDX_W-1:0] lim;
        logic [2:0]       kind;
        logic [1:0]       dpl;
        logic             pres;
        logic             l;
        logic             d;
        logic [SEL_W-1:0] tsel;
        logic             tcode;
        logic             tconf;
        logic [1:0]       tdpl;
        logic             tpres;
        logic             tl;
        logic             td;
    } stim_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [IDX_W-1:0] sel_index = '0;
    logic sel_table = 1'b0;
    logic [1:0] sel_rpl = '0, cur_cpl = '0, dsc_dpl = '0, tgt_dpl = '0;
    logic long_mode = 1'b0;
    logic [IDX_W-1:0] tbl_limit = '0;
    logic [2:0] dsc_kind = '0;
    logic dsc_present = 1'b0, dsc_l = 1'b0, dsc_d = 1'b0;
    logic [SEL_W-1:0] tgt_sel = '0;
    logic tgt_is_code = 1'b0, tgt_conforming = 1'b0, tgt_present = 1'b0;
    logic tgt_l = 1'b0, tgt_d = 1'b0;
    logic res_valid;
    logic [2:0] res_class;
    logic [1:0] res_fault;
    logic [SEL_W-1:0] res_err_sel;
    logic res_more_priv;

    int checks = 0;
    int fails = 0;
    exp_t sb[$];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fcall_priv_check #(.IDX_W(IDX_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .sel_index(sel_index), .sel_table(sel_table), .sel_rpl(sel_rpl),
        .cur_cpl(cur_cpl), .long_mode(long_mode), .tbl_limit(tbl_limit),
        .dsc_kind(dsc_kind), .dsc_dpl(dsc_dpl), .dsc_present(dsc_present),
        .dsc_l(dsc_l), .dsc_d(dsc_d), .tgt_sel(tgt_sel),
        .tgt_is_code(tgt_is_code), .tgt_conforming(tgt_conforming),
        .tgt_dpl(tgt_dpl), .tgt_present(tgt_present), .tgt_l(tgt_l),
        .tgt_d(tgt_d), .res_valid(res_valid), .res_class(res_class),
        .res_fault(res_fault), .res_err_sel(res_err_sel),
        .res_more_priv(res_more_priv)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(stim_t s);
        exp_t e;
        logic [SEL_W-1:0] full;
        full  = {s.idx, s.tbl, s.rpl};
        e.cls = 3'd0; e.fault = 2'd0; e.err = '0; e.mp = 1'b0; e.tag = "R13";
        if (s.idx == 0 && !s.tbl) begin
            e.fault = 2'd1; e.tag = "R1"; return e;
        end
        if (s.idx > s.lim) begin
            e.fault = 2'd1; e.err = full; e.tag = "R2"; return e;
        end
        if (!s.lm && (s.kind == 3'd0 || s.kind == 3'd4)) begin
            e.fault = 2'd1; e.err = full; e.tag = "R3"; return e;
        end
        if (s.lm && !(s.kind == 3'd1 || s.kind == 3'd2 || s.kind == 3'd4)) begin
            e.fault = 2'd1; e.err = full; e.tag = "R4"; return e;
        end
        case (s.kind)
            3'd1: e.cls = 3'd1;
            3'd2: e.cls = 3'd2;
            3'd3, 3'd4: e.cls = 3'd3;
            3'd5: e.cls = 3'd4;
            default: e.cls = 3'd5;
        endcase
        if (e.cls == 3'd1 || e.cls == 3'd2) begin
            if (s.lm && s.l && s.d) begin
                e.fault = 2'd1; e.err = full; e.tag = "R5"; return e;
            end
            if (e.cls == 3'd1 && s.dpl > s.cpl) begin
                e.fault = 2'd1; e.err = full; e.tag = "R6"; return e;
            end
            if (e.cls == 3'd2 && (s.rpl > s.cpl || s.dpl != s.cpl)) begin
                e.fault = 2'd1; e.err = full; e.tag = "R7"; return e;
            end
        end else if (e.cls == 3'd3) begin
            if (s.dpl < s.cpl || s.rpl > s.dpl) begin
                e.fault = 2'd1; e.err = full; e.tag = "R8"; return e;
            end
            if (!s.pres) begin
                e.fault = 2'd2; e.err = full; e.tag = "R8"; return e;
            end
            if (!s.tcode || s.tdpl > s.cpl || (s.lm && !(s.tl && !s.td))) begin
                e.fault = 2'd1; e.err = s.tsel; e.tag = "R9"; return e;
            end
            if (!s.tpres) begin
                e.fault = 2'd2; e.err = s.tsel; e.tag = "R9"; return e;
            end
            e.mp = !s.tconf && (s.tdpl < s.cpl);
            e.tag = "R10";
            return e;
        end else begin
            if (s.dpl < s.cpl || s.dpl < s.rpl ||
                (e.cls == 3'd5 && (s.kind == 3'd7 || s.tbl))) begin
                e.fault = 2'd1; e.err = full; e.tag = "R11"; return e;
            end
        end
        if (!s.pres) begin
            e.fault = 2'd2; e.err = full; e.tag = "R12";
        end
        return e;
    endfunction

    // Driver: apply one request for one cycle and queue its expected verdict.
    task automatic drive(stim_t s);
        @(negedge clk);
        req_valid = 1'b1;
        sel_index = s.idx; sel_table = s.tbl; sel_rpl = s.rpl;
        cur_cpl = s.cpl; long_mode = s.lm; tbl_limit = s.lim;
        dsc_kind = s.kind; dsc_dpl = s.dpl; dsc_present = s.pres;
        dsc_l = s.l; dsc_d = s.d; tgt_sel = s.tsel;
        tgt_is_code = s.tcode; tgt_conforming = s.tconf; tgt_dpl = s.tdpl;
        tgt_present = s.tpres; tgt_l = s.tl; tgt_d = s.td;
        sb.push_back(model(s));
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // A clean, present, same-level stimulus that tests can adjust.
    function automatic stim_t base();
        stim_t s;
        s.idx = 13'd5; s.tbl = 1'b0; s.rpl = 2'd0; s.cpl = 2'd0; s.lm = 1'b0;
        s.lim = 13'd20; s.kind = 3'd2; s.dpl = 2'd0; s.pres = 1'b1;
        s.l = 1'b0; s.d = 1'b1; s.tsel = 16'h0048; s.tcode = 1'b1;
        s.tconf = 1'b0; s.tdpl = 2'd0; s.tpres = 1'b1; s.tl = 1'b1; s.td = 1'b0;
        return s;
    endfunction

    // Monitor: compare each verdict with the oldest queued expectation.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R13: verdict with empty scoreboard, actual class=%0d fault=%0d expected none",
                         res_class, res_fault);
            end else begin
                e = sb.pop_front();
                if (res_class !== e.cls || res_fault !== e.fault ||
                    res_err_sel !== e.err || res_more_priv !== e.mp) begin
                    fails++;
                    $display("FAIL %s: actual cls=%0d fault=%0d err=%h mp=%0d expected cls=%0d fault=%0d err=%h mp=%0d",
                             e.tag, res_class, res_fault, res_err_sel, res_more_priv,
                             e.cls, e.fault, e.err, e.mp);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R13: watchdog expired, actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        stim_t s;
        repeat (3) @(negedge clk);
        // Reset state.
        checks++;
        if (res_valid !== 1'b0 || res_fault !== 2'd0 || res_more_priv !== 1'b0) begin
            fails++;
            $display("FAIL R13: reset actual valid=%0d fault=%0d expected 0 0",
                     res_valid, res_fault);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 null selector; a local index 0 is not null.
        s = base(); s.idx = 0; drive(s);
        s = base(); s.idx = 0; s.tbl = 1'b1; drive(s);
        // R2 limit.
        s = base(); s.idx = 13'd21; drive(s);
        s = base(); s.idx = 13'd20; drive(s);
        // R3 legacy type screen.
        s = base(); s.kind = 3'd0; drive(s);
        s = base(); s.kind = 3'd4; drive(s);
        // R4 long-mode type screen.
        s = base(); s.lm = 1; s.kind = 3'd5; drive(s);
        s = base(); s.lm = 1; s.kind = 3'd3; drive(s);
        s = base(); s.lm = 1; s.kind = 3'd6; drive(s);
        // R5 L and D both set.
        s = base(); s.lm = 1; s.l = 1; s.d = 1; drive(s);
        s = base(); s.lm = 0; s.l = 1; s.d = 1; drive(s);
        // R6 conforming.
        s = base(); s.kind = 3'd1; s.cpl = 2'd1; s.dpl = 2'd2; drive(s);
        s = base(); s.kind = 3'd1; s.cpl = 2'd3; s.dpl = 2'd0; s.rpl = 2'd3; drive(s);
        // R7 nonconforming.
        s = base(); s.cpl = 2'd1; s.dpl = 2'd1; s.rpl = 2'd2; drive(s);
        s = base(); s.cpl = 2'd1; s.dpl = 2'd0; drive(s);
        // R8 gate privilege and presence.
        s = base(); s.kind = 3'd3; s.cpl = 2'd2; s.dpl = 2'd1; drive(s);
        s = base(); s.kind = 3'd3; s.dpl = 2'd1; s.rpl = 2'd2; drive(s);
        s = base(); s.kind = 3'd3; s.dpl = 2'd3; s.pres = 0; s.tcode = 0; drive(s);
        // R9 gate target.
        s = base(); s.kind = 3'd3; s.tcode = 0; drive(s);
        s = base(); s.kind = 3'd3; s.cpl = 2'd1; s.dpl = 2'd3; s.tdpl = 2'd2; drive(s);
        s = base(); s.lm = 1; s.kind = 3'd4; s.tl = 0; drive(s);
        s = base(); s.lm = 1; s.kind = 3'd4; s.td = 1; drive(s);
        s = base(); s.kind = 3'd3; s.tpres = 0; drive(s);
        // R10 privilege path.
        s = base(); s.kind = 3'd3; s.cpl = 2'd3; s.rpl = 2'd3; s.dpl = 2'd3; s.tdpl = 2'd0; drive(s);
        s = base(); s.kind = 3'd3; s.cpl = 2'd3; s.rpl = 2'd3; s.dpl = 2'd3; s.tdpl = 2'd0; s.tconf = 1; drive(s);
        s = base(); s.lm = 1; s.kind = 3'd4; s.cpl = 2'd3; s.dpl = 2'd3; s.tdpl = 2'd3; drive(s);
        // R11 task gate and TSS.
        s = base(); s.kind = 3'd5; s.cpl = 2'd2; s.dpl = 2'd1; drive(s);
        s = base(); s.kind = 3'd6; s.rpl = 2'd3; s.dpl = 2'd2; drive(s);
        s = base(); s.kind = 3'd7; drive(s);
        s = base(); s.kind = 3'd6; s.tbl = 1; drive(s);
        s = base(); s.kind = 3'd5; s.tbl = 1; drive(s);
        // R12 presence after privilege.
        s = base(); s.pres = 0; drive(s);
        s = base(); s.pres = 0; s.cpl = 2'd1; drive(s);
        s = base(); s.kind = 3'd7; s.pres = 0; drive(s);
        idle(); idle();

        // R13 mixed sweep with gaps between requests.
        for (int i = 0; i < 400; i++) begin
            s.idx = 13'($urandom_range(0, 12)); s.tbl = 1'($urandom);
            s.rpl = 2'($urandom); s.cpl = 2'($urandom); s.lm = 1'($urandom);
            s.lim = 13'($urandom_range(0, 12)); s.kind = 3'($urandom);
            s.dpl = 2'($urandom); s.pres = ($urandom_range(0, 3) != 0);
            s.l = 1'($urandom); s.d = 1'($urandom);
            s.tsel = 16'($urandom); s.tcode = ($urandom_range(0, 3) != 0);
            s.tconf = 1'($urandom); s.tdpl = 2'($urandom);
            s.tpres = ($urandom_range(0, 3) != 0); s.tl = 1'($urandom); s.td = 1'($urandom);
            drive(s);
            if (i % 7 == 0) idle();
        end
        idle(); idle(); idle();

        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL R13: pending verdicts actual %0d expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule